// File: doc/BRIEF.md
# Dual Countdown Timer Unit

This block holds two identical countdown timers behind a simple word-wide register port with a write strobe. Each timer has a reload value, a control word and a count that can be read while it runs. The control word carries a two-bit operation code and a tick-source field. The operations are load, hold and run. The source field picks one of several single-cycle tick-enable inputs, which decrement the counter.

When a running counter expires, it reloads from its divisor and sets its own bit in a shared raw interrupt status. A mask register filters that status. A write-one-to-clear acknowledge register clears bits in it. A level interrupt output is high while any masked bit is set. The block is meant for a periodic system tick, a scheduler tick or a short delay, with software acknowledging each expiry.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset both counts read 0, both timers are stopped, the raw status and the mask read 0 and `irq_o` is low. Tick pulses after reset do not move a count.
- R2: Writing a divisor (timer0 at 0x00, timer1 at 0x10) only stores it. The count is unchanged until a control write with operation code 0 (bits [1:0]) copies the divisor into the count.
- R3: A control write with operation code 1 stops the counter. While it is stopped, tick pulses leave the count unchanged.
- R4: A control write with operation code 2 starts the counter. Tick source codes 4..7 in bits [4:2] select `tick_en[0]`..`tick_en[3]`. While running, each pulse on the selected input decrements the count by one. Pulses on the other inputs have no effect.
- R5: Source codes 0 to 3 select no tick, so a running counter with such a code does not advance.
- R6: A control write with operation code 3 is ignored as a whole. The run state and the tick source stay as they were.
- R7: A selected tick that arrives while the count is 1 or 0 reloads the divisor and sets the raw status bit of that timer: bit 0 for timer0, bit 1 for timer1. Counting then goes on periodically, every divisor ticks.
- R8: A write to the acknowledge address 0x4C clears each raw bit written as one and keeps the others. The written value is not kept, so later expiries set their bits again.
- R9: When an expiry and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R10: The masked status at 0x54 equals raw AND mask. `irq_o` is high exactly when the masked status is non-zero, and it follows a mask write (address 0x48) from the next cycle.
- R11: Reads return the count at 0x04 and 0x14, the mask at 0x48, the raw status at 0x50 and the masked status at 0x54, with the mask and status in bits [1:0]. Every other address reads as 0, including the divisor and control addresses. Writes to read-only addresses change nothing.
- R12: The two timers are independent. Writes and ticks aimed at one timer do not change the other timer's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 4 | Single-cycle tick-enable pulses, sources 4..7 |
| irq_o | output | 1 | Level interrupt, OR of the masked status |

## Verification
The bench builds the block with a 32-bit counter and four tick inputs. With these values every legal source code maps to an input, and each code can be checked against pulses on the inputs it did not select. Small divisors of 3 and 5 put expiry, periodic reload and an expiry that coincides with an acknowledge within a few ticks. The two interrupt bits make it possible to show an acknowledge of one bit leaving the other in place.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    // first source code that maps to a tick input
    localparam int SRC_BASE   = 4;

    // per-timer register layout
    localparam int TMR_STRIDE = 16;
    localparam int OFS_DIV    = 0;
    localparam int OFS_DATA   = 4;
    localparam int OFS_CTRL   = 8;

    // shared interrupt registers
    localparam int A_MASK     = 'h48;
    localparam int A_ACK      = 'h4C;
    localparam int A_RAW      = 'h50;
    localparam int A_MASKED   = 'h54;

endpackage

// File: rtl/countdown_unit.sv
module countdown_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [N_SRC-1:0] ticks,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam int SRC_W = $clog2(SRC_BASE + N_SRC);

    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] count;
        logic             run;
        logic [SRC_W-1:0] src;
    } unit_t;

    unit_t unit_d, unit_q;
    logic  tick_sel;
    op_e   op;

    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (unit_q.src == SRC_W'(SRC_BASE + i)) tick_sel = ticks[i];
        end
    end

    always_comb begin
        op       = op_e'(wdata[1:0]);
        unit_d   = unit_q;
        expire_o = 1'b0;
        if (div_wr) unit_d.div = wdata;
        if (ctrl_wr && op != OP_RSVD) begin
            unit_d.src = wdata[SRC_W+1:2];
            case (op)
                OP_LOAD: unit_d.count = unit_q.div;
                OP_HOLD: unit_d.run   = 1'b0;
                OP_RUN:  unit_d.run   = 1'b1;
                default: unit_d.run   = unit_q.run;
            endcase
        end else if (unit_q.run && tick_sel) begin
            if (unit_q.count <= CNT_W'(1)) begin
                unit_d.count = unit_q.div;
                expire_o     = 1'b1;
            end else begin
                unit_d.count = unit_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) unit_q <= '0;
        else        unit_q <= unit_d;
    end

    assign count_o = unit_q.count;

    // R3: a stopped counter only moves on a control write
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_q.run && !ctrl_wr) |=> $stable(unit_q.count));

    // R4: one selected tick takes one off the count
    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_q.run && !ctrl_wr && tick_sel && unit_q.count > CNT_W'(1))
        |=> unit_q.count == $past(unit_q.count) - CNT_W'(1));

    // R7: expiry reloads the divisor
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> unit_q.count == $past(unit_q.div));

    // R6: a reserved operation leaves run state and source alone
    p_rsvd_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[1:0] == 2'd3) |=> ($stable(unit_q.run) && $stable(unit_q.src)));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
    parameter int N_TMR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_TMR-1:0] expire,
    input  logic             mask_wr,
    input  logic             ack_wr,
    input  logic [N_TMR-1:0] wdata,
    output logic [N_TMR-1:0] raw_o,
    output logic [N_TMR-1:0] mask_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [N_TMR-1:0] raw;
        logic [N_TMR-1:0] mask;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (ack_wr)  irq_d.raw  = irq_q.raw & ~wdata;
        irq_d.raw = irq_d.raw | expire;  // set beats clear
        if (mask_wr) irq_d.mask = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign raw_o  = irq_q.raw;
    assign mask_o = irq_q.mask;
    assign irq_o  = |(irq_q.raw & irq_q.mask);

    // R8: acknowledged bits without a new expiry end up clear
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((irq_q.raw & $past(wdata) & ~$past(expire)) == '0));

    // R9: an expiry always leaves its bit set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire != '0) |=> ((irq_q.raw & $past(expire)) == $past(expire)));

    // R10: the mask takes the written value
    p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> irq_q.mask == $past(wdata));

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_SRC  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  tick_en,
    output logic              irq_o
);
    localparam int N_TMR = 2;

    logic [DATA_W-1:0] cnt [N_TMR];
    logic [N_TMR-1:0]  expire;
    logic [N_TMR-1:0]  raw, mask;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        logic div_wr, ctrl_wr;
        assign div_wr  = bus_wr && bus_addr == ADDR_W'(g * TMR_STRIDE + OFS_DIV);
        assign ctrl_wr = bus_wr && bus_addr == ADDR_W'(g * TMR_STRIDE + OFS_CTRL);

        countdown_unit #(
            .CNT_W (DATA_W),
            .N_SRC (N_SRC)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_wr   (div_wr),
            .ctrl_wr  (ctrl_wr),
            .wdata    (bus_wdata),
            .ticks    (tick_en),
            .count_o  (cnt[g]),
            .expire_o (expire[g])
        );
    end

    irq_ctrl #(
        .N_TMR (N_TMR)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .mask_wr (bus_wr && bus_addr == ADDR_W'(A_MASK)),
        .ack_wr  (bus_wr && bus_addr == ADDR_W'(A_ACK)),
        .wdata   (bus_wdata[N_TMR-1:0]),
        .raw_o   (raw),
        .mask_o  (mask),
        .irq_o   (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (bus_addr == ADDR_W'(i * TMR_STRIDE + OFS_DATA)) bus_rdata = cnt[i];
        end
        if (bus_addr == ADDR_W'(A_MASK))   bus_rdata = DATA_W'(mask);
        if (bus_addr == ADDR_W'(A_RAW))    bus_rdata = DATA_W'(raw);
        if (bus_addr == ADDR_W'(A_MASKED)) bus_rdata = DATA_W'(raw & mask);
    end

    // R11: the raw status address is read-only
    p_raw_readonly_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_RAW) && expire == '0) |=> $stable(raw));

    // R1: interrupt low in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !irq_o);

endmodule

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] K_WR  = 3'd0;  // write
    localparam logic [2:0] K_RD  = 3'd1;  // read and compare
    localparam logic [2:0] K_TK  = 3'd2;  // tick pulse, data = tick_en
    localparam logic [2:0] K_IRQ = 3'd3;  // compare irq_o
    localparam logic [2:0] K_WT  = 3'd4;  // write and tick (tick in exp field)

    typedef struct packed {
        logic [2:0]  kind;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t VEC [0:NV-1] = '{
        '{K_WR,  8'h00, 32'd5,    32'd0, 4'd2},   // R2 divisor 5
        '{K_RD,  8'h04, 32'd0,    32'd0, 4'd2},   // R2 store only
        '{K_WR,  8'h08, 32'h10,   32'd0, 4'd2},   // R2 load, src4
        '{K_RD,  8'h04, 32'd0,    32'd5, 4'd2},   // R2
        '{K_WR,  8'h08, 32'h12,   32'd0, 4'd4},   // R4 run src4
        '{K_TK,  8'h00, 32'h1,    32'd0, 4'd4},
        '{K_RD,  8'h04, 32'd0,    32'd4, 4'd4},   // R4
        '{K_TK,  8'h00, 32'hE,    32'd0, 4'd4},
        '{K_RD,  8'h04, 32'd0,    32'd4, 4'd4},   // R4 other inputs
        '{K_WR,  8'h08, 32'h11,   32'd0, 4'd3},   // R3 hold
        '{K_TK,  8'h00, 32'hF,    32'd0, 4'd3},
        '{K_RD,  8'h04, 32'd0,    32'd4, 4'd3},   // R3
        '{K_WR,  8'h08, 32'h12,   32'd0, 4'd6},   // run src4
        '{K_WR,  8'h08, 32'h07,   32'd0, 4'd6},   // R6 op3, src1
        '{K_TK,  8'h00, 32'h1,    32'd0, 4'd6},
        '{K_RD,  8'h04, 32'd0,    32'd3, 4'd6},   // R6 still src4 running
        '{K_WR,  8'h08, 32'h02,   32'd0, 4'd5},   // R5 src0
        '{K_TK,  8'h00, 32'hF,    32'd0, 4'd5},
        '{K_RD,  8'h04, 32'd0,    32'd3, 4'd5},   // R5
        '{K_WR,  8'h08, 32'h06,   32'd0, 4'd5},   // R5 src1
        '{K_TK,  8'h00, 32'hF,    32'd0, 4'd5},
        '{K_RD,  8'h04, 32'd0,    32'd3, 4'd5},   // R5
        '{K_WR,  8'h08, 32'h1E,   32'd0, 4'd4},   // R4 run src7
        '{K_TK,  8'h00, 32'h8,    32'd0, 4'd4},
        '{K_TK,  8'h00, 32'h8,    32'd0, 4'd4},
        '{K_RD,  8'h04, 32'd0,    32'd1, 4'd4},   // R4
        '{K_RD,  8'h50, 32'd0,    32'd0, 4'd7},   // R7 not yet
        '{K_TK,  8'h00, 32'h8,    32'd0, 4'd7},
        '{K_RD,  8'h04, 32'd0,    32'd5, 4'd7},   // R7 reload
        '{K_RD,  8'h50, 32'd0,    32'd1, 4'd7},   // R7 bit0
        '{K_RD,  8'h54, 32'd0,    32'd0, 4'd10},  // R10 mask 0
        '{K_WR,  8'h48, 32'd3,    32'd0, 4'd10},
        '{K_RD,  8'h54, 32'd0,    32'd1, 4'd10},  // R10
        '{K_IRQ, 8'h00, 32'd0,    32'd1, 4'd10},  // R10
        '{K_WR,  8'h48, 32'd0,    32'd0, 4'd10},
        '{K_IRQ, 8'h00, 32'd0,    32'd0, 4'd10},  // R10
        '{K_WR,  8'h48, 32'd1,    32'd0, 4'd10},
        '{K_IRQ, 8'h00, 32'd0,    32'd1, 4'd10},  // R10
        '{K_WR,  8'h4C, 32'd2,    32'd0, 4'd8},   // R8 other bit
        '{K_RD,  8'h50, 32'd0,    32'd1, 4'd8},   // R8
        '{K_WR,  8'h4C, 32'd1,    32'd0, 4'd8},
        '{K_RD,  8'h50, 32'd0,    32'd0, 4'd8},   // R8
        '{K_IRQ, 8'h00, 32'd0,    32'd0, 4'd8},   // R8
        '{K_WR,  8'h10, 32'd3,    32'd0, 4'd12},  // timer1 divisor 3
        '{K_WR,  8'h18, 32'h14,   32'd0, 4'd12},  // load, src5
        '{K_RD,  8'h14, 32'd0,    32'd3, 4'd2},   // R2
        '{K_RD,  8'h04, 32'd0,    32'd5, 4'd12},  // R12
        '{K_WR,  8'h18, 32'h16,   32'd0, 4'd12},  // run src5
        '{K_TK,  8'h00, 32'h2,    32'd0, 4'd7},
        '{K_TK,  8'h00, 32'h2,    32'd0, 4'd7},
        '{K_TK,  8'h00, 32'h2,    32'd0, 4'd7},
        '{K_RD,  8'h50, 32'd0,    32'd2, 4'd7},   // R7 bit1
        '{K_RD,  8'h14, 32'd0,    32'd3, 4'd7},   // R7 reload
        '{K_RD,  8'h04, 32'd0,    32'd5, 4'd12},  // R12
        '{K_IRQ, 8'h00, 32'd0,    32'd0, 4'd10},  // R10 bit1 masked
        '{K_TK,  8'h00, 32'h2,    32'd0, 4'd7},
        '{K_RD,  8'h14, 32'd0,    32'd2, 4'd7},   // R7 periodic
        '{K_TK,  8'h00, 32'h2,    32'd0, 4'd9}    // count now 1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_en = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_tick_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .irq_o     (irq_o)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [3:0] t);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick_en = t;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic irq_chk(input logic exp, input int req);
        @(negedge clk);
        check(req, 32'(irq_o), 32'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        rd(8'h04, 32'd0, 1);
        rd(8'h14, 32'd0, 1);
        rd(8'h50, 32'd0, 1);
        rd(8'h48, 32'd0, 1);
        irq_chk(1'b0, 1);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].kind)
                K_WR:  cyc(1'b1, VEC[i].addr, VEC[i].data, 4'h0);
                K_RD:  rd(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
                K_TK:  cyc(1'b0, 8'h00, 32'd0, VEC[i].data[3:0]);
                K_IRQ: irq_chk(VEC[i].exp[0], int'(VEC[i].req));
                default: cyc(1'b1, VEC[i].addr, VEC[i].data, VEC[i].exp[3:0]);
            endcase
        end

        // R9: expiry of timer1 and its acknowledge in the same cycle
        cyc(1'b1, 8'h4C, 32'd2, 4'h2);
        rd(8'h50, 32'd2, 9);
        rd(8'h14, 32'd3, 9);
        // R8: acknowledge, then a later expiry sets the bit again
        cyc(1'b1, 8'h4C, 32'd2, 4'h0);
        rd(8'h50, 32'd0, 8);
        for (int k = 0; k < 3; k++) cyc(1'b0, 8'h00, 32'd0, 4'h2);
        rd(8'h50, 32'd2, 8);

        // R11: unmapped and write-only addresses read zero, read-only writes ignored
        rd(8'h20, 32'd0, 11);
        rd(8'h00, 32'd0, 11);
        rd(8'h08, 32'd0, 11);
        cyc(1'b1, 8'h50, 32'hFFFF_FFFF, 4'h0);
        rd(8'h50, 32'd2, 11);
        cyc(1'b1, 8'h54, 32'hFFFF_FFFF, 4'h0);
        rd(8'h48, 32'd1, 11);
        cyc(1'b1, 8'h48, 32'hFFFF_FFFF, 4'h0);
        rd(8'h48, 32'd3, 11);
        rd(8'h54, 32'd2, 10);
        irq_chk(1'b1, 10);

        // R1: reset in the middle of activity
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check(1, 32'(irq_o), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        rd(8'h50, 32'd0, 1);
        rd(8'h48, 32'd0, 1);
        cyc(1'b0, 8'h00, 32'd0, 4'hF);
        rd(8'h04, 32'd0, 1);
        rd(8'h14, 32'd0, 1);
        irq_chk(1'b0, 1);

        finish_run();
    end
endmodule